// File: doc/BRIEF.md
# Double-Buffered Process Image

This block holds the cyclic process data exchanged between a network engine and a host processor. The input image is kept in two banks. At any moment the network side fills one bank while the host reads the other. When the cycle latch strobe arrives, the two banks trade roles in a single clock edge. The host therefore only ever sees input words that belong to one cycle.

Output words written by the host go into a staging copy first. The network side reads a separate active copy, and that copy is loaded from the staging copy only at the latch point. A 16-bit version number advances on every bank swap. The host reads the version, then the payload, then the version again, and retries within the same window if the two version reads differ.

A latch strobe that arrives while the network side is in the middle of a write burst is held back until the burst ends, and a sticky overrun flag records the event. Host accesses are meant to fall inside the host window. An access outside that window is still carried out, but a sticky violation flag records it.

Top module: `pimg_dbuf`

## Requirements
- R1: After reset the version is 0, the overrun and violation flags are 0, every input word read by the host is 0, and every active output word seen by the network is 0.
- R2: A network write goes to the bank hidden from the host. Host reads do not see it before the next swap.
- R3: A swap happens on any clock edge where a latch is requested (new strobe or deferred) and `net_busy_i` is low. After that edge, host reads return the bank the network was filling before the swap. A network write in the swap cycle lands in the bank that becomes host-visible.
- R4: A latch strobe while `net_busy_i` is high is deferred. The swap happens on the first edge with `net_busy_i` low, and `overrun_o` is set on the edge after the strobe and stays set until reset.
- R5: `version_o` increments by exactly 1 per swap, wraps modulo 65536, and is unchanged on every edge without a swap.
- R6: A host output write changes only the staging copy. `net_rdata_o` changes only at a swap edge, when the whole active copy is loaded from the staging copy. A host write in that same cycle is included in the load.
- R7: A host read (`host_rd_i` high) returns the addressed word of the host-visible bank on `host_rdata_o` after the next edge. If that edge is a swap, the word comes from the pre-swap bank. `host_rdata_o` holds its value between reads.
- R8: A host read or write while `host_win_i` is low is still performed, and `win_viol_o` is set on the next edge and stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| latch_i | input | 1 | Cycle latch / commit strobe |
| net_busy_i | input | 1 | Network write burst in progress |
| net_we_i | input | 1 | Network input-word write enable |
| net_waddr_i | input | 3 | Network input-word address |
| net_wdata_i | input | 32 | Network input-word data |
| net_raddr_i | input | 3 | Network active-output read address |
| net_rdata_o | output | 32 | Active output word (combinational) |
| host_win_i | input | 1 | Host access window open |
| host_rd_i | input | 1 | Host input-word read strobe |
| host_raddr_i | input | 3 | Host read address |
| host_rdata_o | output | 32 | Host read data, registered |
| host_wr_i | input | 1 | Host output-word write strobe |
| host_waddr_i | input | 3 | Host output-word write address |
| host_wdata_i | input | 32 | Host output-word data |
| version_o | output | 16 | Swap version counter |
| overrun_o | output | 1 | Sticky: latch arrived during a write burst |
| win_viol_o | output | 1 | Sticky: host access outside the window |

## Verification
The swap edge is where most interactions meet. Three cases fall on it: a host read issued in the swap cycle, a host output write issued in the commit cycle, and a network write issued in the swap cycle. The bench places these on purpose, and random traffic also brings latch strobes into the same cycles as reads, writes and the fall of the busy signal. A behavioural reference model, updated on every edge with its own ordering rules (pre-swap read, write folded into the commit), is compared against all outputs on every cycle. A run of 65536 consecutive swaps then checks that the version wraps back to its starting value.

// File: rtl/pimg_pkg.sv
package pimg_pkg;
  localparam int VER_W = 16;
  typedef logic [VER_W-1:0] ver_t;

  // next version value, wraps modulo 2^VER_W
  function automatic ver_t ver_step(input ver_t v);
    return v + ver_t'(1);
  endfunction

  // a swap fires when a latch is wanted and no burst is open
  function automatic logic swap_go(input logic strobe, input logic pend, input logic busy);
    return (strobe | pend) & ~busy;
  endfunction
endpackage

// File: rtl/pimg_swap_ctl.sv
module pimg_swap_ctl
  import pimg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic latch_i,
  input  logic busy_i,
  output logic swap_o,
  output logic sel_o,
  output ver_t version_o,
  output logic overrun_o
);
  logic pend_q;
  logic late_latch;

  assign swap_o     = swap_go(latch_i, pend_q, busy_i);
  assign late_latch = latch_i & busy_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q    <= 1'b0;
      sel_o     <= 1'b0;
      version_o <= '0;
      overrun_o <= 1'b0;
    end else begin
      pend_q <= (latch_i | pend_q) & busy_i;
      if (late_latch) overrun_o <= 1'b1;
      if (swap_o) begin
        sel_o     <= ~sel_o;
        version_o <= ver_step(version_o);
      end
    end
  end

  p_defer_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    late_latch |=> overrun_o);
  p_ovr_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_o |=> overrun_o);
  p_ver_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    swap_o |=> (version_o == ver_step($past(version_o))));
  p_ver_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !swap_o |=> $stable(version_o));
  p_sel_flip_r3: assert property (@(posedge clk) disable iff (!rst_n)
    swap_o |=> (sel_o != $past(sel_o)));
endmodule

// File: rtl/pimg_in_banks.sv
module pimg_in_banks #(
  parameter int DATA_W = 32,
  parameter int WORDS  = 8,
  localparam int AW    = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rd_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] word_q [2][WORDS];

  for (genvar b = 0; b < 2; b++) begin : g_bank
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int i = 0; i < WORDS; i++) word_q[b][i] <= '0;
      end else if (we_i && (sel_i == b[0])) begin
        word_q[b][waddr_i] <= wdata_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    rdata_o <= '0;
    else if (rd_i) rdata_o <= word_q[~sel_i][raddr_i];
  end

  p_rd_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_i |=> $stable(rdata_o));
endmodule

// File: rtl/pimg_out_stage.sv
module pimg_out_stage #(
  parameter int DATA_W = 32,
  parameter int WORDS  = 8,
  localparam int AW    = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit_i,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [WORDS-1:0][DATA_W-1:0] stage_q, stage_d, active_q;

  always_comb begin
    stage_d = stage_q;
    if (we_i) stage_d[waddr_i] = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q  <= '0;
      active_q <= '0;
    end else begin
      stage_q <= stage_d;
      if (commit_i) active_q <= stage_d;
    end
  end

  assign rdata_o = active_q[raddr_i];

  p_out_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_i |=> $stable(active_q));
  p_out_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    commit_i |=> (active_q == stage_q));
endmodule

// File: rtl/pimg_dbuf.sv
module pimg_dbuf
  import pimg_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int IN_WORDS  = 8,
  parameter int OUT_WORDS = 8,
  localparam int IA_W     = $clog2(IN_WORDS),
  localparam int OA_W     = $clog2(OUT_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              latch_i,
  input  logic              net_busy_i,
  input  logic              net_we_i,
  input  logic [IA_W-1:0]   net_waddr_i,
  input  logic [DATA_W-1:0] net_wdata_i,
  input  logic [OA_W-1:0]   net_raddr_i,
  output logic [DATA_W-1:0] net_rdata_o,
  input  logic              host_win_i,
  input  logic              host_rd_i,
  input  logic [IA_W-1:0]   host_raddr_i,
  output logic [DATA_W-1:0] host_rdata_o,
  input  logic              host_wr_i,
  input  logic [OA_W-1:0]   host_waddr_i,
  input  logic [DATA_W-1:0] host_wdata_i,
  output logic [VER_W-1:0]  version_o,
  output logic              overrun_o,
  output logic              win_viol_o
);
  logic swap_evt;
  logic bank_sel;
  logic stray_access;

  assign stray_access = (host_rd_i | host_wr_i) & ~host_win_i;

  pimg_swap_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .latch_i(latch_i), .busy_i(net_busy_i),
    .swap_o(swap_evt), .sel_o(bank_sel), .version_o(version_o), .overrun_o(overrun_o)
  );

  pimg_in_banks #(.DATA_W(DATA_W), .WORDS(IN_WORDS)) u_in (
    .clk(clk), .rst_n(rst_n), .sel_i(bank_sel),
    .we_i(net_we_i), .waddr_i(net_waddr_i), .wdata_i(net_wdata_i),
    .rd_i(host_rd_i), .raddr_i(host_raddr_i), .rdata_o(host_rdata_o)
  );

  pimg_out_stage #(.DATA_W(DATA_W), .WORDS(OUT_WORDS)) u_out (
    .clk(clk), .rst_n(rst_n), .commit_i(swap_evt),
    .we_i(host_wr_i), .waddr_i(host_waddr_i), .wdata_i(host_wdata_i),
    .raddr_i(net_raddr_i), .rdata_o(net_rdata_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            win_viol_o <= 1'b0;
    else if (stray_access) win_viol_o <= 1'b1;
  end

  p_viol_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stray_access |=> win_viol_o);
  p_viol_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    win_viol_o |=> win_viol_o);
  p_swap_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    swap_evt |-> !net_busy_i);
endmodule

// File: tb/pimg_dbuf_tb.sv
module pimg_dbuf_tb;
  localparam int DW = 32;
  localparam int NW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic latch, busy, nwe, hwin, hrd, hwr;
  logic [2:0] nwa, nra, hra, hwa;
  logic [DW-1:0] nwd, hwd, nrd, hrdat;
  logic [15:0] ver;
  logic ovr, viol;

  int tests = 0;
  int fails = 0;
  string tag = "R1";

  always #4 clk = ~clk;

  pimg_dbuf u_dut (
    .clk(clk), .rst_n(rst_n), .latch_i(latch), .net_busy_i(busy),
    .net_we_i(nwe), .net_waddr_i(nwa), .net_wdata_i(nwd),
    .net_raddr_i(nra), .net_rdata_o(nrd),
    .host_win_i(hwin), .host_rd_i(hrd), .host_raddr_i(hra), .host_rdata_o(hrdat),
    .host_wr_i(hwr), .host_waddr_i(hwa), .host_wdata_i(hwd),
    .version_o(ver), .overrun_o(ovr), .win_viol_o(viol)
  );

  // behavioural reference model
  logic [DW-1:0] m_img [2][NW];
  logic [DW-1:0] m_stage [NW];
  logic [DW-1:0] m_act [NW];
  logic [DW-1:0] m_rd;
  int  m_side, m_ver;
  bit  m_want, m_ovr, m_viol;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NW; i++) begin
        m_img[0][i] = '0; m_img[1][i] = '0; m_stage[i] = '0; m_act[i] = '0;
      end
      m_rd = '0; m_side = 0; m_ver = 0; m_want = 0; m_ovr = 0; m_viol = 0;
    end else begin
      bit go;
      go = (latch || m_want) && !busy;
      if (hrd) m_rd = m_img[1 - m_side][hra];
      if (nwe) m_img[m_side][nwa] = nwd;
      if (hwr) m_stage[hwa] = hwd;
      if (go) for (int i = 0; i < NW; i++) m_act[i] = m_stage[i];
      if (latch && busy) m_ovr = 1;
      m_want = (latch || m_want) && busy;
      if ((hrd || hwr) && !hwin) m_viol = 1;
      if (go) begin
        m_side = 1 - m_side;
        m_ver = (m_ver + 1) % 65536;
      end
    end
  end

  task automatic check(input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      check("version", 32'(ver), 32'(m_ver));
      check("overrun", 32'(ovr), 32'(m_ovr));
      check("violation", 32'(viol), 32'(m_viol));
      check("host_rdata", hrdat, m_rd);
      check("net_rdata", nrd, m_act[nra]);
    end
  end

  task automatic idle();
    latch = 0; busy = 0; nwe = 0; hrd = 0; hwr = 0; hwin = 1;
    nwa = 0; nra = 0; hra = 0; hwa = 0; nwd = 0; hwd = 0;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    tag = "R1";
    step();
    check("reset version", 32'(ver), 0);
    check("reset net_rdata", nrd, 0);

    // R2: net writes hidden until swap
    tag = "R2";
    for (int i = 0; i < NW; i++) begin
      nwe = 1; nwa = 3'(i); nwd = 32'hA000 + i; step();
    end
    nwe = 0; hrd = 1; hra = 3'd5; step();
    check("hidden word", hrdat, 0);
    hrd = 0;

    // R3: swap exposes data; net write in swap cycle lands in exposed bank
    tag = "R3";
    latch = 1; nwe = 1; nwa = 3'd2; nwd = 32'hBEEF; step();
    latch = 0; nwe = 0; hrd = 1; hra = 3'd2; step();
    check("swap-cycle write visible", hrdat, 32'hBEEF);
    hra = 3'd5; step();
    check("exposed word", hrdat, 32'hA005);
    hrd = 0;

    // R7: read in the swap cycle returns pre-swap bank
    tag = "R7";
    nwe = 1; nwa = 3'd1; nwd = 32'h7777; step(); nwe = 0;
    hrd = 1; hra = 3'd1; latch = 1; step();
    check("pre-swap read", hrdat, 32'hA001);
    latch = 0; step();
    check("post-swap read", hrdat, 32'h7777);
    hrd = 0;

    // R6: staged outputs, same-cycle write included in commit
    tag = "R6";
    hwr = 1; hwa = 3'd4; hwd = 32'h1234; step();
    hwr = 0; nra = 3'd4; step();
    check("not yet active", nrd, 0);
    hwr = 1; hwa = 3'd6; hwd = 32'h5678; latch = 1; step();
    hwr = 0; latch = 0; nra = 3'd6; step();
    check("commit-cycle write", nrd, 32'h5678);
    nra = 3'd4; step();
    check("staged word committed", nrd, 32'h1234);

    // R4: latch during a burst is deferred, overrun set
    tag = "R4";
    busy = 1; nwe = 1; nwa = 3'd0; nwd = 32'hCAFE; latch = 1; step();
    latch = 0; nwd = 32'hCAFF; step();
    check("overrun set", 32'(ovr), 1);
    busy = 0; nwe = 0; step();
    hrd = 1; hra = 3'd0; step();
    check("deferred swap exposes burst", hrdat, 32'hCAFF);
    hrd = 0;

    // R8: access outside window still done, flag set
    tag = "R8";
    hwin = 0; hwr = 1; hwa = 3'd3; hwd = 32'h99; step();
    hwin = 1; hwr = 0; latch = 1; step(); latch = 0; nra = 3'd3; step();
    check("violation set", 32'(viol), 1);
    check("write still done", nrd, 32'h99);

    // random mixed traffic, compared every clock against the model
    tag = "R3";
    for (int n = 0; n < 3000; n++) begin
      latch = ($urandom % 5) == 0;
      busy  = ($urandom % 4) == 0;
      nwe = $urandom % 2; nwa = 3'($urandom); nwd = $urandom;
      hrd = $urandom % 2; hra = 3'($urandom);
      hwr = $urandom % 2; hwa = 3'($urandom); hwd = $urandom;
      hwin = ($urandom % 8) != 0; nra = 3'($urandom);
      step();
    end
    idle(); step();

    // R5: version wraps after 65536 swaps
    tag = "R5";
    begin
      logic [15:0] v0;
      v0 = ver;
      latch = 1;
      repeat (65536) step();
      latch = 0; step();
      check("wrap", 32'(ver), 32'(v0));
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule